// File: doc/BRIEF.md
# Shadow-Loaded Time-of-Day Counter with Framesync Commit

This block keeps a hardware time of day for a precision time protocol clock. It runs from a nominal 125 MHz clock. A 32-bit frequency word is added to a 28-bit fraction accumulator on every clock, and the whole nanoseconds that carry out advance three counters. The first is a nanosecond counter that wraps into a 48-bit seconds counter. The second is a free-running 48-bit nanosecond count, called the NCO time. The word value 0x8000_0000 gives exactly 8 ns per clock.

Software never changes the running time directly. Writes to the time code, the NCO time and the frequency word land in shadow registers. A framesync event commits them all in one clock edge. A framesync comes from a 0-to-1 write of the host trigger bit or from a rising edge on an external sync pin. The same event can also snapshot the current seconds and nanoseconds into four heartbeat words and raise a status flag. A start/end handshake keeps the snapshot stable while software reads it out.

The register bus is a flat word-addressed write/read strobe port. Read data appears one clock after the read strobe.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the time outputs are zero and the clock advances 8 ns per clock. The frequency word resets to 0x8000_0000, where bits [31:28] are whole nanoseconds and bits [27:0] are the fraction. The frequency shadow reads back 0x8000 at address 12.
- R2: The nanosecond output stays below NS_WRAP. When an advance reaches NS_WRAP, NS_WRAP is subtracted and the seconds output increments.
- R3: The frequency shadow is written as a low half (address 11) and a high half (address 12). It becomes the running frequency at a framesync if load-select (address 1) bit 6 is set, or if the permission register (address 2) bit 6 is set. The fraction carries between clocks, so 0x8800_0000 advances 17 ns every two clocks.
- R4: A write to the control register (address 0) starts a host framesync only when it sets bit 0 while the stored bit 0 is 0. Writing 1 over 1 starts nothing.
- R5: The time code shadow is held at addresses 3..7: nanoseconds low and high, then seconds in three 16-bit words, least significant first. The NCO time shadow is held at addresses 8..10, which carry nanosecond bits [19:4], [35:20] and [47:36]. Each is loaded at a framesync only when control bit 1 (init) is set for that event and load-select bit 10 (time code) or bit 7 (NCO time) is set. Load-select bits 10 and 7 then clear. Without init, nothing is loaded and the select bits remain.
- R6: With control bit 2 (capture) set, a framesync latches the nanoseconds and seconds of the cycle before the event into heartbeat words at addresses 15..18 (ns low, ns high, s low, s high). It also sets status bit 0 (address 13).
- R7: Writing bit 0 of the heartbeat control register (address 14) locks the heartbeat words and blocks capture. Writing bit 1 while locked releases the lock and clears status bit 0.
- R8: With control bit 3 set, a rising edge on `ext_sync_in` acts as a framesync after a SYNC_STAGES-flop synchronizer. With SYNC_STAGES = 2, a level first sampled high at edge k commits at edge k+2.
- R9: `rdata` takes the value of the register addressed with `rd_en` on the next clock edge and holds it otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz nominal clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| ext_sync_in | input | 1 | Asynchronous external framesync input |
| tod_sec | output | 48 | Seconds of the time of day |
| tod_ns | output | 30 | Nanoseconds of the time of day |
| nco_ns | output | 48 | Free-running NCO nanosecond count |

## Verification
The bench sets NS_WRAP to 1000 and keeps SYNC_STAGES at 2. At 8 ns per clock, a simulated second then lasts 125 clocks. Seconds carries, wraps in the middle of a frequency change and loads over a wrap therefore all fall within a few hundred cycles. The short wrap also lets the two-clock advance under fractional frequency words be measured directly. The external-sync latency is checked against the two-flop count.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int NS_W    = 30;
    localparam int SEC_W   = 48;
    localparam int NCO_W   = 48;
    localparam int FREQ_W  = 32;
    localparam int FRAC_W  = 28;
    localparam int INC_W   = FREQ_W - FRAC_W + 1;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int CTL_W   = 4;
    localparam int SH_NUM  = 10;
    localparam int HB_NUM  = 4;
    localparam int SH_IDX_W = $clog2(SH_NUM);

    localparam logic [FREQ_W-1:0] FREQ_NOMINAL = 32'h8000_0000;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_LDSEL  = 5'd1;
    localparam logic [ADDR_W-1:0] A_PERMIT = 5'd2;
    localparam logic [ADDR_W-1:0] A_SH0    = 5'd3;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'd13;
    localparam logic [ADDR_W-1:0] A_HBCTL  = 5'd14;
    localparam logic [ADDR_W-1:0] A_HB0    = 5'd15;

    localparam int CTL_FSYNC = 0;
    localparam int CTL_INIT  = 1;
    localparam int CTL_CAPT  = 2;
    localparam int CTL_EXT   = 3;

    localparam int SEL_TC  = 10;
    localparam int SEL_NT  = 7;
    localparam int SEL_FRQ = 6;

    // shadow word slots relative to A_SH0
    localparam int SH_TC_NS0 = 0;
    localparam int SH_TC_S0  = 2;
    localparam int SH_NT0    = 5;
    localparam int SH_FRQ0   = 8;

    typedef struct packed {
        logic              ld_freq;
        logic              ld_tc;
        logic              ld_nco;
        logic [FREQ_W-1:0] freq;
        logic [NS_W-1:0]   tc_ns;
        logic [SEC_W-1:0]  tc_sec;
        logic [NCO_W-1:0]  nco;
    } commit_t;

    function automatic logic [WORD_W-1:0] sh_reset(input int idx);
        if (idx == SH_FRQ0)     return FREQ_NOMINAL[WORD_W-1:0];
        if (idx == SH_FRQ0 + 1) return FREQ_NOMINAL[FREQ_W-1:WORD_W];
        return '0;
    endfunction
endpackage

// File: rtl/ptp_tod_sync.sv
module ptp_tod_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[SYNC_STAGES-1];
    end

    assign rise = stage_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
    import ptp_tod_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [WORD_W-1:0]              wdata,
    input  logic                           ext_rise,
    input  logic [HB_NUM-1:0][WORD_W-1:0]  hb_words,
    input  logic                           fsync_flag,
    output logic [WORD_W-1:0]              rdata,
    output commit_t                        commit,
    output logic                           cap_fire,
    output logic                           init_evt,
    output logic                           hb_start,
    output logic                           hb_end,
    output logic [WORD_W-1:0]              sel_q
);
    logic [CTL_W-1:0]  ctrl_q;
    logic [CTL_W-1:0]  ctrl_eff;
    logic [WORD_W-1:0] permit_q;
    logic [WORD_W-1:0] sel_next;
    logic [WORD_W-1:0] sh_q [SH_NUM];
    logic              ctrl_wr;
    logic              evt;
    logic              in_sh;
    logic [SH_IDX_W-1:0] sh_idx;
    logic [ADDR_W-1:0] sh_off;

    assign ctrl_wr  = wr_en && (addr == A_CTRL);
    assign ctrl_eff = ctrl_wr ? wdata[CTL_W-1:0] : ctrl_q;
    assign evt      = (ctrl_wr && wdata[CTL_FSYNC] && !ctrl_q[CTL_FSYNC])
                    || (ext_rise && ctrl_eff[CTL_EXT]);
    assign init_evt = evt && ctrl_eff[CTL_INIT];
    assign cap_fire = evt && ctrl_eff[CTL_CAPT];
    assign hb_start = wr_en && (addr == A_HBCTL) && wdata[0];
    assign hb_end   = wr_en && (addr == A_HBCTL) && wdata[1];

    assign sh_off = addr - A_SH0;
    assign sh_idx = sh_off[SH_IDX_W-1:0];
    assign in_sh  = (addr >= A_SH0) && (addr < A_SH0 + ADDR_W'(SH_NUM));

    always_comb begin
        commit.ld_freq = evt && (sel_q[SEL_FRQ] || permit_q[SEL_FRQ]);
        commit.ld_tc   = init_evt && sel_q[SEL_TC];
        commit.ld_nco  = init_evt && sel_q[SEL_NT];
        commit.freq    = {sh_q[SH_FRQ0+1], sh_q[SH_FRQ0]};
        commit.tc_ns   = NS_W'({sh_q[SH_TC_NS0+1], sh_q[SH_TC_NS0]});
        commit.tc_sec  = {sh_q[SH_TC_S0+2], sh_q[SH_TC_S0+1], sh_q[SH_TC_S0]};
        commit.nco     = {sh_q[SH_NT0+2][11:0], sh_q[SH_NT0+1], sh_q[SH_NT0], 4'b0000};
    end

    always_comb begin
        sel_next = (wr_en && addr == A_LDSEL) ? wdata : sel_q;
        if (init_evt) begin
            sel_next[SEL_TC] = 1'b0;
            sel_next[SEL_NT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            permit_q <= '0;
            sel_q    <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata[CTL_W-1:0];
            if (wr_en && addr == A_PERMIT) permit_q <= wdata;
            sel_q <= sel_next;
        end
    end

    generate
        for (genvar g = 0; g < SH_NUM; g++) begin : g_sh
            always_ff @(posedge clk) begin
                if (rst) sh_q[g] <= sh_reset(g);
                else if (wr_en && addr == A_SH0 + ADDR_W'(g)) sh_q[g] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (in_sh) begin
                rdata <= sh_q[sh_idx];
            end else begin
                case (addr)
                    A_CTRL:     rdata <= WORD_W'(ctrl_q);
                    A_LDSEL:    rdata <= sel_q;
                    A_PERMIT:   rdata <= permit_q;
                    A_STAT:     rdata <= WORD_W'(fsync_flag);
                    A_HB0:      rdata <= hb_words[0];
                    A_HB0 + 1:  rdata <= hb_words[1];
                    A_HB0 + 2:  rdata <= hb_words[2];
                    A_HB0 + 3:  rdata <= hb_words[3];
                    default:    rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int NS_WRAP = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  commit_t          commit,
    output logic [NS_W-1:0]  ns_q,
    output logic [SEC_W-1:0] sec_q,
    output logic [NCO_W-1:0] nco_q
);
    localparam logic [NS_W:0] WRAP_V = (NS_W+1)'(NS_WRAP);

    logic [FREQ_W-1:0] freq_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FREQ_W:0]   step;
    logic [INC_W-1:0]  inc;
    logic [NS_W:0]     ns_sum;
    logic [NS_W-1:0]   ns_adv;
    logic              carry;

    assign step   = {(INC_W)'(0), acc_q} + {1'b0, freq_q};
    assign inc    = step[FREQ_W:FRAC_W];
    assign ns_sum = {1'b0, ns_q} + (NS_W+1)'(inc);
    assign carry  = ns_sum >= WRAP_V;
    assign ns_adv = carry ? NS_W'(ns_sum - WRAP_V) : ns_sum[NS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q <= FREQ_NOMINAL;
            acc_q  <= '0;
            ns_q   <= '0;
            sec_q  <= '0;
            nco_q  <= '0;
        end else begin
            acc_q <= step[FRAC_W-1:0];
            if (commit.ld_freq) freq_q <= commit.freq;
            if (commit.ld_tc) begin
                ns_q  <= commit.tc_ns;
                sec_q <= commit.tc_sec;
            end else begin
                ns_q  <= ns_adv;
                sec_q <= sec_q + SEC_W'(carry);
            end
            if (commit.ld_nco) nco_q <= commit.nco;
            else               nco_q <= nco_q + NCO_W'(inc);
        end
    end
endmodule

// File: rtl/ptp_tod_hb.sv
module ptp_tod_hb
    import ptp_tod_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cap_fire,
    input  logic                          hb_start,
    input  logic                          hb_end,
    input  logic [NS_W-1:0]               ns,
    input  logic [SEC_W-1:0]              sec,
    output logic [HB_NUM-1:0][WORD_W-1:0] hb_words,
    output logic                          fsync_flag,
    output logic                          hb_lock
);
    logic [2*WORD_W-1:0] ns_ext;

    assign ns_ext = (2*WORD_W)'(ns);

    always_ff @(posedge clk) begin
        if (rst) begin
            hb_words   <= '0;
            fsync_flag <= 1'b0;
            hb_lock    <= 1'b0;
        end else begin
            if (cap_fire && !hb_lock) begin
                hb_words   <= {sec[2*WORD_W-1:WORD_W], sec[WORD_W-1:0],
                               ns_ext[2*WORD_W-1:WORD_W], ns_ext[WORD_W-1:0]};
                fsync_flag <= 1'b1;
            end
            if (hb_end && hb_lock) begin
                hb_lock    <= 1'b0;
                fsync_flag <= 1'b0;
            end else if (hb_start) begin
                hb_lock <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int NS_WRAP     = 1_000_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [4:0]        addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic              ext_sync_in,
    output logic [47:0]       tod_sec,
    output logic [29:0]       tod_ns,
    output logic [47:0]       nco_ns
);
    commit_t                        commit;
    logic                           ext_rise;
    logic                           cap_fire;
    logic                           init_evt;
    logic                           hb_start;
    logic                           hb_end;
    logic                           hb_lock;
    logic                           fsync_flag;
    logic [WORD_W-1:0]              sel_q;
    logic [HB_NUM-1:0][WORD_W-1:0]  hb_words;

    ptp_tod_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_sync_in), .rise(ext_rise)
    );

    ptp_tod_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ext_rise(ext_rise), .hb_words(hb_words),
        .fsync_flag(fsync_flag), .rdata(rdata), .commit(commit),
        .cap_fire(cap_fire), .init_evt(init_evt), .hb_start(hb_start),
        .hb_end(hb_end), .sel_q(sel_q)
    );

    ptp_tod_counter #(.NS_WRAP(NS_WRAP)) u_cnt (
        .clk(clk), .rst(rst), .commit(commit),
        .ns_q(tod_ns), .sec_q(tod_sec), .nco_q(nco_ns)
    );

    ptp_tod_hb u_hb (
        .clk(clk), .rst(rst), .cap_fire(cap_fire), .hb_start(hb_start),
        .hb_end(hb_end), .ns(tod_ns), .sec(tod_sec), .hb_words(hb_words),
        .fsync_flag(fsync_flag), .hb_lock(hb_lock)
    );
endmodule

// File: rtl/ptp_tod_clock_chk.sv
module ptp_tod_clock_chk #(
    parameter int NS_WRAP = 1_000_000_000
) (
    input logic        clk,
    input logic        rst,
    input logic [29:0] tod_ns,
    input logic [47:0] tod_sec,
    input logic        ld_tc,
    input logic        cap_fire,
    input logic        init_evt,
    input logic        fsync_flag,
    input logic        hb_lock,
    input logic [15:0] hb_w0,
    input logic [15:0] hb_w2,
    input logic [15:0] sel_q
);
    // R2
    ns_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(tod_ns) < NS_WRAP);

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_tc |=> (tod_sec == $past(tod_sec)) || (tod_sec == $past(tod_sec) + 48'd1));

    // R6
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync_flag) |-> $past(cap_fire));

    // R7
    hb_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        hb_lock |=> $stable(hb_w0) && $stable(hb_w2));

    // R5
    sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        init_evt |=> !sel_q[10] && !sel_q[7]);
endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(.NS_WRAP(NS_WRAP)) u_chk (
    .clk(clk), .rst(rst), .tod_ns(tod_ns), .tod_sec(tod_sec),
    .ld_tc(commit.ld_tc), .cap_fire(cap_fire), .init_evt(init_evt),
    .fsync_flag(fsync_flag), .hb_lock(hb_lock), .hb_w0(hb_words[0]),
    .hb_w2(hb_words[2]), .sel_q(sel_q)
);

// File: tb/test_ptp_tod_clock.sv
module test_ptp_tod_clock;
    localparam int WRAP = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ext_sync_in = 1'b0;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;
    logic [47:0] nco_ns;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ptp_tod_clock #(.NS_WRAP(WRAP), .SYNC_STAGES(2)) i_ptp_tod_clock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_sync_in(ext_sync_in),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .nco_ns(nco_ns)
    );

    // ---------------- behavioural reference model ----------------
    longint      m_ns, m_sec, m_nco;
    longint      m_freq, m_acc;
    logic [3:0]  m_ctrl;
    logic [15:0] m_sel, m_perm, m_rd;
    logic [15:0] m_sh [10];
    logic [15:0] m_hb [4];
    bit          m_stat, m_lock;
    bit          m_s0, m_s1, m_prev;

    function automatic logic [15:0] m_read(input logic [4:0] a);
        if (a >= 3 && a <= 12) return m_sh[a-3];
        case (a)
            0:  return {12'h0, m_ctrl};
            1:  return m_sel;
            2:  return m_perm;
            13: return {15'h0, m_stat};
            15: return m_hb[0];
            16: return m_hb[1];
            17: return m_hb[2];
            18: return m_hb[3];
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ns = 0; m_sec = 0; m_nco = 0; m_acc = 0;
            m_freq = 64'h8000_0000;
            m_ctrl = 0; m_sel = 0; m_perm = 0; m_rd = 0;
            for (int i = 0; i < 10; i++) m_sh[i] = 16'h0;
            m_sh[9] = 16'h8000;
            for (int i = 0; i < 4; i++) m_hb[i] = 16'h0;
            m_stat = 0; m_lock = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
        end else begin
            bit cw, evt, rise, init, cap, ldf, ldt, ldn;
            logic [3:0] ce;
            longint stp, inc, old_ns, old_sec;
            rise = m_s1 && !m_prev;
            m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_sync_in;
            cw  = wr_en && addr == 0;
            ce  = cw ? wdata[3:0] : m_ctrl;
            evt = (cw && wdata[0] && !m_ctrl[0]) || (rise && ce[3]);
            init = evt && ce[1];
            cap  = evt && ce[2];
            ldf = evt && (m_sel[6] || m_perm[6]);
            ldt = init && m_sel[10];
            ldn = init && m_sel[7];
            old_ns = m_ns; old_sec = m_sec;
            stp = m_acc + m_freq;
            inc = stp / (64'd1 << 28);
            m_acc = stp % (64'd1 << 28);
            if (ldt) begin
                m_ns  = longint'({m_sh[1], m_sh[0]}) % (64'd1 << 30);
                m_sec = longint'({m_sh[4], m_sh[3], m_sh[2]});
            end else begin
                m_ns = m_ns + inc;
                if (m_ns >= WRAP) begin m_ns = m_ns - WRAP; m_sec = m_sec + 1; end
            end
            if (ldn) m_nco = longint'({m_sh[7][11:0], m_sh[6], m_sh[5], 4'h0});
            else     m_nco = (m_nco + inc) % (64'd1 << 48);
            if (rd_en) m_rd = m_read(addr);
            if (ldf) m_freq = longint'({m_sh[9], m_sh[8]});
            if (cap && !m_lock) begin
                m_hb[0] = old_ns[15:0];  m_hb[1] = old_ns[31:16];
                m_hb[2] = old_sec[15:0]; m_hb[3] = old_sec[31:16];
                m_stat = 1;
            end
            if (wr_en && addr == 14) begin
                if (wdata[1] && m_lock) begin m_lock = 0; m_stat = 0; end
                else if (wdata[0]) m_lock = 1;
            end
            if (wr_en && addr == 1) m_sel = wdata;
            if (init) begin m_sel[10] = 0; m_sel[7] = 0; end
            if (cw) m_ctrl = wdata[3:0];
            if (wr_en && addr == 2) m_perm = wdata;
            if (wr_en && addr >= 3 && addr <= 12) m_sh[addr-3] = wdata;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(longint'(tod_ns) == m_ns,   "R2 tod_ns",  longint'(tod_ns), m_ns);
            check(longint'(tod_sec) == m_sec, "R2 tod_sec", longint'(tod_sec), m_sec);
            check(longint'(nco_ns) == m_nco,  "R5 nco_ns",  longint'(nco_ns), m_nco);
            check(rdata == m_rd,              "R9 rdata",   longint'(rdata), longint'(m_rd));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v, hb_a;
        longint n1, n2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(tod_ns == 0 && tod_sec == 0, "R1 reset time", longint'(tod_ns), 0);
        rd(13, v); check(v == 16'h0, "R1 status after reset", v, 0);
        rd(12, v); check(v == 16'h8000, "R1 freq shadow reset", v, 16'h8000);
        n1 = tod_ns; @(negedge clk);
        check(tod_ns == n1 + 8, "R1 8 ns per clock", longint'(tod_ns), n1 + 8);
        // R2 run across several seconds
        idle(300);
        check(tod_sec >= 2, "R2 seconds carry", longint'(tod_sec), 2);
        // R3 frequency via load select
        wr(11, 16'h0000); wr(12, 16'h8800);
        wr(1, 16'h0040);
        wr(0, 16'h0001);
        n1 = tod_ns; idle(2); n2 = tod_ns;
        check((n2 + WRAP - n1) % WRAP == 17, "R3 8.5 ns word", (n2 + WRAP - n1) % WRAP, 17);
        // R3 frequency via permission bit
        wr(1, 16'h0000); wr(0, 16'h0000);
        wr(11, 16'h0000); wr(12, 16'h7800);
        wr(2, 16'h0040);
        wr(0, 16'h0001);
        n1 = tod_ns; idle(2); n2 = tod_ns;
        check((n2 + WRAP - n1) % WRAP == 15, "R3 permit 7.5 ns word", (n2 + WRAP - n1) % WRAP, 15);
        wr(2, 16'h0000);
        // R5 without init: no load, select retained
        wr(3, 16'd500); wr(4, 16'h0); wr(5, 16'h0002); wr(6, 16'h0001); wr(7, 16'h0);
        wr(8, 16'h0001); wr(9, 16'h0); wr(10, 16'h0);
        wr(0, 16'h0000);
        wr(1, 16'h0480);
        wr(0, 16'h0001);
        rd(1, v); check(v == 16'h0480, "R5 select kept without init", v, 16'h0480);
        check(tod_sec != 48'h1_0002, "R5 no load without init", longint'(tod_sec), 0);
        // R5 with init
        wr(0, 16'h0000);
        wr(1, 16'h04C0);
        @(negedge clk); wr_en = 1'b1; addr = 0; wdata = 16'h0003;
        @(negedge clk); wr_en = 1'b0;
        check(tod_ns == 500 && tod_sec == 48'h1_0002, "R5 time code load",
              longint'(tod_sec), 48'h1_0002);
        check(nco_ns == 48'd16, "R5 NCO time in 16 ns units", longint'(nco_ns), 16);
        rd(1, v); check(v == 16'h0040, "R5 select self-clear", v, 16'h0040);
        wr(1, 16'h0000);
        // R6 capture
        wr(0, 16'h0004);
        @(negedge clk); wr_en = 1'b1; addr = 0; wdata = 16'h0005; n1 = tod_ns;
        @(negedge clk); wr_en = 1'b0;
        rd(13, v); check(v == 16'h1, "R6 status set", v, 1);
        rd(15, v); check(longint'(v) == n1, "R6 heartbeat ns", v, n1);
        // R7 lock freezes heartbeat
        wr(14, 16'h0001);
        rd(15, hb_a);
        wr(0, 16'h0004); wr(0, 16'h0005);
        rd(15, v); check(v == hb_a, "R7 frozen heartbeat", v, hb_a);
        wr(14, 16'h0002);
        rd(13, v); check(v == 16'h0, "R7 status cleared", v, 0);
        // R4 writing 1 over 1 is not an event
        wr(0, 16'h0005);
        rd(13, v); check(v == 16'h0, "R4 no event on 1 over 1", v, 0);
        // R8 external sync
        wr(0, 16'h000C);
        @(negedge clk); ext_sync_in = 1'b1;
        idle(4); ext_sync_in = 1'b0;
        rd(13, v); check(v == 16'h1, "R8 external framesync", v, 1);
        wr(14, 16'h0001); wr(14, 16'h0002);
        wr(0, 16'h0004);
        @(negedge clk); ext_sync_in = 1'b1;
        idle(4); ext_sync_in = 1'b0;
        rd(13, v); check(v == 16'h0, "R8 ignored when disabled", v, 0);
        // R9 unmapped read
        rd(25, v); check(v == 16'h0, "R9 unmapped read", v, 0);
        idle(200);
        finish_run();
    end
endmodule